// File: doc/BRIEF.md
# Dual-Bank Multiply-Accumulate Engine

This block computes a dot product of two operand streams held in two separate
on-chip banks: a coefficient bank and a sample bank. A single start pulse
latches an iteration count, a base address and a signed stride for each bank.
The engine then steps both read pointers together on every clock. Each pointer
has its own adder, and the two banks are read in the same cycle over separate
read ports. The engine therefore issues one multiply-accumulate per clock, with
no cycles spent on loop control. Each product is registered at twice the
operand width and then added into a wide accumulator that has guard bits.

Software or a loader first fills the banks through a shared write port. It then
pulses start and waits for the one-cycle done pulse, at which point the
accumulator output holds the result. A sample stride of -1 walks the sample
bank backwards, which is the usual access pattern of a direct-form FIR tap sum.

Top module: `mac_engine`

## Requirements
- R1: After reset, `acc_out` is zero and `busy` and `done` are low.
- R2: When `wr_en` is high, `wr_data` is written at `wr_addr` into the bank chosen by `wr_bank`. The value 0 selects the coefficient bank and 1 selects the sample bank.
- R3: A run with count N leaves `acc_out` equal to the sum over i = 0..N-1 of coef[(cbase + i*cstride) mod 64] * samp[(sbase + i*sstride) mod 64]. The operands are 16-bit signed values.
- R4: Each stride is a 6-bit two's complement value that is applied independently to its own pointer. Pointers wrap modulo the bank depth of 64, and a stride of zero rereads the same word.
- R5: When start is accepted at clock edge E with count N > 0, `busy` is high from E onward and `done` pulses at edge E+N+3. This timing means one product is accumulated per cycle.
- R6: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R7: The accumulator is 40 bits wide and wraps modulo 2^40 on overflow.
- R8: An accepted start clears `acc_out` to zero at the edge that accepts it.
- R9: A start pulse that arrives while `busy` is high is ignored. The run in progress keeps its configuration, its timing and its result.
- R10: A count of zero makes `done` pulse one edge after the accepting edge, and `acc_out` stays zero.
- R11: Outside an active run, `acc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bank write strobe |
| wr_bank | input | 1 | 0 = coefficient bank, 1 = sample bank |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data, signed |
| start | input | 1 | Run request pulse |
| count | input | 10 | Iteration count |
| coef_base | input | 6 | Coefficient start address |
| coef_stride | input | 6 | Coefficient pointer step, signed |
| samp_base | input | 6 | Sample start address |
| samp_stride | input | 6 | Sample pointer step, signed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 40 | Accumulator |

## Verification
The assertions check on every cycle that `done` is a single-cycle pulse that never coincides with `busy`. They also check that an accepted start clears the accumulator, that the accumulator and both pointers hold while nothing is stepping them, and that the pipeline never carries a product without a preceding read. Only the bench scenarios can show the arithmetic result of whole runs under different stride and wrap patterns, the exact done latency of N+3, 40-bit wrap-around, and that a start issued mid-run leaves that run unchanged.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OPW_DEF   = 16;
  localparam int ADRW_DEF  = 6;
  localparam int CNTW_DEF  = 10;
  localparam int GUARD_DEF = 8;
  localparam int NBANKS    = 2;
  typedef enum logic {BANK_COEF = 1'b0, BANK_SAMP = 1'b1} bank_e;
endpackage

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int OPW  = 16,
  parameter int ADRW = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [ADRW-1:0] waddr,
  input  logic [OPW-1:0]  wdata,
  input  logic            re,
  input  logic [ADRW-1:0] raddr,
  output logic [OPW-1:0]  rdata
);
  localparam int DEPTH = 1 << ADRW;
  logic [OPW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/addr_step.sv
module addr_step #(
  parameter int ADRW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ADRW-1:0] base,
  input  logic [ADRW-1:0] stride,
  input  logic            step,
  output logic [ADRW-1:0] ptr
);
  logic [ADRW-1:0] stride_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      stride_q <= '0;
    end else if (load) begin
      ptr      <= base;
      stride_q <= stride;
    end else if (step) begin
      ptr <= ptr + stride_q;
    end
  end

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(ptr));
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic signed [OPW-1:0]   opa,
  input  logic signed [OPW-1:0]   opb,
  output logic                    prod_vld,
  output logic [2*OPW+GUARD-1:0]  acc
);
  localparam int PW = 2 * OPW;
  localparam int AW = PW + GUARD;
  logic signed [PW-1:0] prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod     <= '0;
      prod_vld <= 1'b0;
      acc      <= '0;
    end else begin
      prod_vld <= in_vld;
      if (in_vld) prod <= opa * opb;
      if (clr) acc <= '0;
      else if (prod_vld) acc <= acc + AW'(prod);
    end
  end

  // R8
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0));
  // R11
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !prod_vld) |=> $stable(acc));
  // R5
  prod_src_chk: assert property (@(posedge clk) disable iff (rst)
    prod_vld |-> $past(in_vld));
endmodule

// File: rtl/mac_engine.sv
module mac_engine
  import mac_pkg::*;
#(
  parameter int OPW   = OPW_DEF,
  parameter int ADRW  = ADRW_DEF,
  parameter int CNTW  = CNTW_DEF,
  parameter int GUARD = GUARD_DEF,
  localparam int ACCW = 2 * OPW + GUARD
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [ADRW-1:0] wr_addr,
  input  logic [OPW-1:0]  wr_data,
  input  logic            start,
  input  logic [CNTW-1:0] count,
  input  logic [ADRW-1:0] coef_base,
  input  logic [ADRW-1:0] coef_stride,
  input  logic [ADRW-1:0] samp_base,
  input  logic [ADRW-1:0] samp_stride,
  output logic            busy,
  output logic            done,
  output logic [ACCW-1:0] acc_out
);
  logic [CNTW-1:0] remain;
  logic            accept, issue, rd_vld, prod_vld, drained;
  logic [ADRW-1:0] base_v   [NBANKS];
  logic [ADRW-1:0] stride_v [NBANKS];
  logic [ADRW-1:0] ptr      [NBANKS];
  logic [OPW-1:0]  rdat     [NBANKS];

  assign accept = start && !busy;
  assign issue  = busy && (remain != '0);
  assign drained = busy && (remain == '0) && !rd_vld && !prod_vld;

  assign base_v[BANK_COEF]   = coef_base;
  assign base_v[BANK_SAMP]   = samp_base;
  assign stride_v[BANK_COEF] = coef_stride;
  assign stride_v[BANK_SAMP] = samp_stride;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    addr_step #(.ADRW(ADRW)) u_ptr (
      .clk(clk), .rst(rst), .load(accept), .base(base_v[g]),
      .stride(stride_v[g]), .step(issue), .ptr(ptr[g])
    );
    bank_ram #(.OPW(OPW), .ADRW(ADRW)) u_ram (
      .clk(clk), .we(wr_en && (wr_bank == 1'(g))), .waddr(wr_addr),
      .wdata(wr_data), .re(issue), .raddr(ptr[g]), .rdata(rdat[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= issue;
      done   <= drained;
      if (accept) begin
        busy   <= 1'b1;
        remain <= count;
      end else begin
        if (issue)   remain <= remain - 1'b1;
        if (drained) busy   <= 1'b0;
      end
    end
  end

  mac_unit #(.OPW(OPW), .GUARD(GUARD)) u_mac (
    .clk(clk), .rst(rst), .clr(accept), .in_vld(rd_vld),
    .opa(rdat[BANK_COEF]), .opb(rdat[BANK_SAMP]),
    .prod_vld(prod_vld), .acc(acc_out)
  );

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> busy);
endmodule

// File: tb/tb_mac_engine.sv
`timescale 1ns/1ps
module tb_mac_engine;
  localparam int D = 64;
  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_bank = 0, start = 0;
  logic [5:0] wr_addr = 0, cb = 0, cs = 0, sb = 0, ss = 0;
  logic [15:0] wr_data = 0;
  logic [9:0] count = 0;
  logic busy, done;
  logic [39:0] acc_out;
  int checks = 0, fails = 0;
  logic signed [15:0] cm [D];
  logic signed [15:0] sm [D];

  always #2.5 clk = ~clk;

  mac_engine dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .count(count), .coef_base(cb),
    .coef_stride(cs), .samp_base(sb), .samp_stride(ss),
    .busy(busy), .done(done), .acc_out(acc_out)
  );

  // stimulus table: coef base, coef stride, samp base, samp stride, count
  localparam int VEC [6][5] = '{
    '{0, 1, 0, 1, 16},
    '{5, 1, 40, -1, 20},
    '{60, 3, 2, -5, 30},
    '{10, 0, 10, 0, 8},
    '{0, 1, 63, 1, 64},
    '{7, 2, 9, -3, 1}
  };

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic bank, input int a, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1; wr_bank = bank; wr_addr = 6'(a); wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [39:0] model(int c0, int c1, int s0, int s1, int n);
    longint s = 0;
    for (int i = 0; i < n; i++)
      s += longint'(cm[(c0 + i*c1) & 63]) * longint'(sm[(s0 + i*s1) & 63]);
    return s[39:0];
  endfunction

  // pulses start, returns edges until done is seen
  task automatic run(input int c0, input int c1, input int s0, input int s1,
                     input int n, input bit mid_start, output int lat);
    @(negedge clk);
    cb = 6'(c0); cs = 6'(c1); sb = 6'(s0); ss = 6'(s1); count = 10'(n);
    start = 1;
    @(posedge clk); #1;
    chk("R8 clear on start", longint'(acc_out), 0);
    @(negedge clk); start = 0;
    lat = 0;
    while (1) begin
      @(posedge clk); #1;
      lat++;
      if (mid_start && lat == 3) begin
        @(negedge clk);
        cb = 0; cs = 0; sb = 0; ss = 0; count = 0; start = 1;
        @(posedge clk); #1; lat++;
        @(negedge clk); start = 0;
      end
      if (done) break;
      if (lat > 3000) begin
        chk("watchdog run", lat, -1);
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    chk("watchdog global", 0, 1);
    summary();
  end

  initial begin
    int lat;
    logic [39:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 acc", longint'(acc_out), 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    @(negedge clk); rst = 0;

    // R2: fill both banks
    for (int i = 0; i < D; i++) begin
      cm[i] = 16'(i * 2749 + 123);
      sm[i] = 16'(77 - i * 1931);
      wr(1'b0, i, cm[i]);
      wr(1'b1, i, sm[i]);
    end

    // R2: a single-term run reads back one written word of each bank
    run(13, 1, 50, 1, 1, 0, lat);
    chk("R2 single term", longint'(acc_out),
        longint'(cm[13]) * longint'(sm[50]) & 40'hFF_FFFF_FFFF);

    // R3 R4 R5: table
    for (int v = 0; v < 6; v++) begin
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, lat);
      chk("R3 R4 result", longint'(acc_out),
          longint'(model(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4])));
      chk("R5 latency", lat, VEC[v][4] + 3);
    end

    // R6: done lasts one cycle
    @(posedge clk); #1;
    chk("R6 done pulse", done, 0);
    chk("R6 busy low", busy, 0);

    // R11: accumulator holds while idle
    held = acc_out;
    repeat (5) @(posedge clk);
    #1;
    chk("R11 hold", longint'(acc_out), longint'(held));

    // R10: count zero
    run(3, 1, 3, 1, 0, 0, lat);
    chk("R10 latency", lat, 1);
    chk("R10 acc zero", longint'(acc_out), 0);

    // R9: start mid-run ignored
    run(4, 1, 30, -1, 12, 1, lat);
    chk("R9 latency", lat, 15);
    chk("R9 result", longint'(acc_out), longint'(model(4, 1, 30, -1, 12)));

    // R7: wrap with largest-magnitude products, 1023 * 2^30 mod 2^40
    for (int i = 0; i < D; i++) begin
      cm[i] = 16'sh8000;
      sm[i] = 16'sh8000;
      wr(1'b0, i, cm[i]);
      wr(1'b1, i, sm[i]);
    end
    run(0, 1, 0, 1, 1023, 0, lat);
    chk("R7 wrap", longint'(acc_out), longint'(40'hFF_C000_0000));
    chk("R5 latency long", lat, 1026);

    summary();
  end
endmodule